// File: doc/BRIEF.md
# Pipelined Floating-Point Adder

This block adds two floating-point operands in four registered steps. Each operand carries a sign, a two's-complement exponent and an unsigned magnitude fraction. The binary point sits just left of the fraction's most significant bit, so an operand's value is (-1)^sign × 0.fraction × 2^exponent. The first step compares the exponents and picks the operand with the larger one. The second shifts the other operand's fraction right to line it up. The third adds or subtracts the magnitudes. The fourth brings the result back to the normalized range 0.5 ≤ d < 1 and corrects the exponent to match.

The block accepts one operand pair on every clock and returns results in issue order, each tagged with a valid flag. The input side is a valid strobe with no ready signal. The block never applies back-pressure and never stalls, so any pair presented with `in_valid` high is always consumed on that edge. The output has no ready either, and the consumer must take each result in the cycle it is flagged. Rounding is by truncation only. Exponent arithmetic wraps modulo 2^EXP_W.

Top module: `fpadd_pipe`

## Requirements
- R1: An operand or result word is a sign bit (1 = negative), an EXP_W-bit two's-complement exponent and a FRAC_W-bit magnitude fraction with the binary point before its MSB. With the defaults (EXP_W = 8, FRAC_W = 16), 16'h8000 stands for 0.5.
- R2: A pair presented with `in_valid` high on a rising edge yields its result with `out_valid` high after exactly four rising edges. Pairs may arrive on consecutive edges, so n back-to-back pairs finish in 4 + (n − 1) cycles, and results leave in arrival order.
- R3: While reset is asserted, and afterwards until a newly accepted pair emerges, `out_valid` is low. Work in flight when reset arrives is discarded.
- R4: The larger exponent, compared as signed values, becomes the working exponent. When the exponents are equal, operand A is treated as the larger. The other fraction is shifted right by the exponent difference, and the bits shifted out are discarded.
- R5: An exponent difference of FRAC_W or more makes the aligned fraction zero. A difference of FRAC_W − 1 keeps only the top bit.
- R6: When the signs match, the aligned magnitudes are added and the result takes that common sign. When the signs differ, the smaller aligned magnitude is subtracted from the larger and the result takes the sign of the larger.
- R7: When the magnitude sum overflows the fraction width, the sum is shifted right one place, its lowest bit is dropped, and the working exponent is incremented.
- R8: A zero magnitude sum produces sign 0, exponent 0 and fraction 0.
- R9: A nonzero sum with no overflow is shifted left by its count of leading zeros, so the output fraction's MSB is 1. The working exponent is reduced by that same count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_sign | input | 1 | Sign of operand A |
| a_exp | input | EXP_W | Exponent of operand A (two's complement) |
| a_frac | input | FRAC_W | Magnitude fraction of operand A |
| b_sign | input | 1 | Sign of operand B |
| b_exp | input | EXP_W | Exponent of operand B (two's complement) |
| b_frac | input | FRAC_W | Magnitude fraction of operand B |
| out_valid | output | 1 | Result present this cycle |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | EXP_W | Exponent of the result |
| out_frac | output | FRAC_W | Normalized magnitude fraction of the result |

## Verification
The bench builds the block with its defaults: an 8-bit exponent and a 16-bit fraction. The exponent span of −128 to 127 lets the vectors produce shift distances of 15, 16 and up to 255, which covers both sides of the alignment saturation edge and the signed-compare extremes. The 16-bit fraction allows a near-total cancellation whose result needs a 15-place left shift. Back-to-back streams of the table and of a six-pair burst check the one-per-cycle rate and the fixed latency. A reset in the middle of a stream shows that work in flight is discarded.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Which correction the final stage applies to the raw magnitude sum.
  typedef enum logic [1:0] {
    NORM_SHIFT = 2'd0,
    NORM_CARRY = 2'd1,
    NORM_ZERO  = 2'd2
  } norm_act_e;
endpackage

// File: rtl/fpadd_cmp_stage.sv
module fpadd_cmp_stage #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SH_W   = EXP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic              v_q,
  output logic              big_sign_q,
  output logic [FRAC_W-1:0] big_frac_q,
  output logic              sml_sign_q,
  output logic [FRAC_W-1:0] sml_frac_q,
  output logic [EXP_W-1:0]  r_exp_q,
  output logic [SH_W-1:0]   shift_q
);
  logic [SH_W-1:0] diff_ab;
  logic            a_is_big;

  always_comb begin
    diff_ab  = {a_exp[EXP_W-1], a_exp} - {b_exp[EXP_W-1], b_exp};
    a_is_big = ~diff_ab[SH_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= 1'b0;
      big_sign_q <= 1'b0;
      big_frac_q <= '0;
      sml_sign_q <= 1'b0;
      sml_frac_q <= '0;
      r_exp_q    <= '0;
      shift_q    <= '0;
    end else begin
      v_q <= v_in;
      if (a_is_big) begin
        big_sign_q <= a_sign;
        big_frac_q <= a_frac;
        sml_sign_q <= b_sign;
        sml_frac_q <= b_frac;
        r_exp_q    <= a_exp;
        shift_q    <= diff_ab;
      end else begin
        big_sign_q <= b_sign;
        big_frac_q <= b_frac;
        sml_sign_q <= a_sign;
        sml_frac_q <= a_frac;
        r_exp_q    <= b_exp;
        shift_q    <= -diff_ab;
      end
    end
  end

  // R2: the stage passes its valid bit through one register.
  a_r2_cmp_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v_q == $past(v_in)));

  // R4: the kept exponent is at least as large as either input exponent.
  a_r4_exp_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && v_q) |->
      (($signed(r_exp_q) >= $signed($past(a_exp))) &&
       ($signed(r_exp_q) >= $signed($past(b_exp)))));
endmodule

// File: rtl/fpadd_align_stage.sv
module fpadd_align_stage #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16,
  parameter int SH_W   = EXP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              big_sign,
  input  logic [FRAC_W-1:0] big_frac,
  input  logic              sml_sign,
  input  logic [FRAC_W-1:0] sml_frac,
  input  logic [EXP_W-1:0]  r_exp,
  input  logic [SH_W-1:0]   shift,
  output logic              v_q,
  output logic              big_sign_q,
  output logic [FRAC_W-1:0] big_frac_q,
  output logic              sml_sign_q,
  output logic [FRAC_W-1:0] aln_frac_q,
  output logic [EXP_W-1:0]  r_exp_q
);
  localparam int CMP_W = (SH_W > 32) ? SH_W : 32;

  logic [FRAC_W-1:0] aligned;

  always_comb begin
    if (CMP_W'(shift) >= CMP_W'(FRAC_W)) aligned = '0;
    else                                 aligned = sml_frac >> shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= 1'b0;
      big_sign_q <= 1'b0;
      big_frac_q <= '0;
      sml_sign_q <= 1'b0;
      aln_frac_q <= '0;
      r_exp_q    <= '0;
    end else begin
      v_q        <= v_in;
      big_sign_q <= big_sign;
      big_frac_q <= big_frac;
      sml_sign_q <= sml_sign;
      aln_frac_q <= aligned;
      r_exp_q    <= r_exp;
    end
  end

  // R2: valid travels one register per stage.
  a_r2_align_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v_q == $past(v_in)));

  // R4: a right shift can never enlarge the fraction.
  a_r4_align_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(v_in)) |-> (aln_frac_q <= $past(sml_frac)));
endmodule

// File: rtl/fpadd_addsub_stage.sv
module fpadd_addsub_stage #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              big_sign,
  input  logic [FRAC_W-1:0] big_frac,
  input  logic              sml_sign,
  input  logic [FRAC_W-1:0] aln_frac,
  input  logic [EXP_W-1:0]  r_exp,
  output logic              v_q,
  output logic              sign_q,
  output logic [FRAC_W:0]   sum_q,
  output logic [EXP_W-1:0]  r_exp_q
);
  logic [FRAC_W:0] sum_d;
  logic            sign_d;

  always_comb begin
    if (big_sign == sml_sign) begin
      sum_d  = {1'b0, big_frac} + {1'b0, aln_frac};
      sign_d = big_sign;
    end else if (big_frac >= aln_frac) begin
      sum_d  = {1'b0, big_frac - aln_frac};
      sign_d = big_sign;
    end else begin
      sum_d  = {1'b0, aln_frac - big_frac};
      sign_d = sml_sign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      sign_q  <= 1'b0;
      sum_q   <= '0;
      r_exp_q <= '0;
    end else begin
      v_q     <= v_in;
      sign_q  <= sign_d;
      sum_q   <= sum_d;
      r_exp_q <= r_exp;
    end
  end

  // R2: valid travels one register per stage.
  a_r2_add_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v_q == $past(v_in)));

  // R6: an effective subtraction never overflows the fraction width.
  a_r6_sub_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(v_in) && ($past(big_sign) != $past(sml_sign)))
      |-> !sum_q[FRAC_W]);
endmodule

// File: rtl/fpadd_norm_stage.sv
module fpadd_norm_stage
  import fpadd_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16,
  parameter int LZ_W   = $clog2(FRAC_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic              sign,
  input  logic [FRAC_W:0]   sum,
  input  logic [EXP_W-1:0]  r_exp,
  output logic              v_q,
  output logic              sign_q,
  output logic [EXP_W-1:0]  exp_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic [LZ_W-1:0]   lz;
  logic              hit;
  norm_act_e         act;
  logic              n_sign;
  logic [EXP_W-1:0]  n_exp;
  logic [FRAC_W-1:0] n_frac;

  // Leading-zero count of the low FRAC_W bits of the sum.
  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!hit && sum[i]) begin
        lz  = LZ_W'(FRAC_W - 1 - i);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (sum[FRAC_W]) act = NORM_CARRY;
    else if (!hit)   act = NORM_ZERO;
    else             act = NORM_SHIFT;

    case (act)
      NORM_CARRY: begin
        n_frac = sum[FRAC_W:1];
        n_exp  = r_exp + EXP_W'(1);
        n_sign = sign;
      end
      NORM_ZERO: begin
        n_frac = '0;
        n_exp  = '0;
        n_sign = 1'b0;
      end
      default: begin
        n_frac = sum[FRAC_W-1:0] << lz;
        n_exp  = r_exp - EXP_W'(lz);
        n_sign = sign;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      sign_q <= 1'b0;
      exp_q  <= '0;
      frac_q <= '0;
    end else begin
      v_q    <= v_in;
      sign_q <= n_sign;
      exp_q  <= n_exp;
      frac_q <= n_frac;
    end
  end

  // R2: valid travels one register per stage.
  a_r2_norm_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (v_q == $past(v_in)));

  // R9: every nonzero result leaves with its top fraction bit set.
  a_r9_msb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (frac_q != '0)) |-> frac_q[FRAC_W-1]);

  // R8: a zero fraction is always a clean positive zero.
  a_r8_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && (frac_q == '0)) |-> ((exp_q == '0) && !sign_q));
endmodule

// File: rtl/fpadd_pipe.sv
module fpadd_pipe #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [FRAC_W-1:0] b_frac,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac
);
  localparam int SH_W = EXP_W + 1;

  logic              s1_v, s1_bsg, s1_ssg;
  logic [FRAC_W-1:0] s1_bfr, s1_sfr;
  logic [EXP_W-1:0]  s1_r;
  logic [SH_W-1:0]   s1_sh;

  logic              s2_v, s2_bsg, s2_ssg;
  logic [FRAC_W-1:0] s2_bfr, s2_afr;
  logic [EXP_W-1:0]  s2_r;

  logic              s3_v, s3_sg;
  logic [FRAC_W:0]   s3_sum;
  logic [EXP_W-1:0]  s3_r;

  fpadd_cmp_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .v_in(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .v_q(s1_v), .big_sign_q(s1_bsg), .big_frac_q(s1_bfr),
    .sml_sign_q(s1_ssg), .sml_frac_q(s1_sfr),
    .r_exp_q(s1_r), .shift_q(s1_sh)
  );

  fpadd_align_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SH_W(SH_W)) u_align (
    .clk(clk), .rst_n(rst_n), .v_in(s1_v),
    .big_sign(s1_bsg), .big_frac(s1_bfr),
    .sml_sign(s1_ssg), .sml_frac(s1_sfr),
    .r_exp(s1_r), .shift(s1_sh),
    .v_q(s2_v), .big_sign_q(s2_bsg), .big_frac_q(s2_bfr),
    .sml_sign_q(s2_ssg), .aln_frac_q(s2_afr), .r_exp_q(s2_r)
  );

  fpadd_addsub_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_add (
    .clk(clk), .rst_n(rst_n), .v_in(s2_v),
    .big_sign(s2_bsg), .big_frac(s2_bfr),
    .sml_sign(s2_ssg), .aln_frac(s2_afr), .r_exp(s2_r),
    .v_q(s3_v), .sign_q(s3_sg), .sum_q(s3_sum), .r_exp_q(s3_r)
  );

  fpadd_norm_stage #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .clk(clk), .rst_n(rst_n), .v_in(s3_v),
    .sign(s3_sg), .sum(s3_sum), .r_exp(s3_r),
    .v_q(out_valid), .sign_q(out_sign), .exp_q(out_exp), .frac_q(out_frac)
  );
endmodule

// File: tb/sim_fpadd_pipe.sv
module sim_fpadd_pipe;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 16;
  localparam int NV     = 15;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              a_sign = 1'b0, b_sign = 1'b0;
  logic [EXP_W-1:0]  a_exp = '0, b_exp = '0;
  logic [FRAC_W-1:0] a_frac = '0, b_frac = '0;
  logic              out_valid, out_sign;
  logic [EXP_W-1:0]  out_exp;
  logic [FRAC_W-1:0] out_frac;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fpadd_pipe #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .a_sign(a_sign), .a_exp(a_exp), .a_frac(a_frac),
    .b_sign(b_sign), .b_exp(b_exp), .b_frac(b_frac),
    .out_valid(out_valid), .out_sign(out_sign),
    .out_exp(out_exp), .out_frac(out_frac)
  );

  // {a_sign,a_exp,a_frac, b_sign,b_exp,b_frac, exp_sign,exp_exp,exp_frac}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0,8'h01,16'h8000, 1'b0,8'h01,16'h8000, 1'b0,8'h02,16'h8000}, // 0 R7 carry
    {1'b0,8'h03,16'h8000, 1'b0,8'h01,16'h8000, 1'b0,8'h03,16'hA000}, // 1 R4 align by 2
    {1'b0,8'h00,16'hC000, 1'b1,8'h00,16'h8000, 1'b0,8'hFF,16'h8000}, // 2 R6 R9 subtract
    {1'b1,8'h02,16'h8000, 1'b0,8'h02,16'hC000, 1'b0,8'h01,16'h8000}, // 3 R6 sign of larger
    {1'b0,8'h05,16'h9000, 1'b1,8'h05,16'h9000, 1'b0,8'h00,16'h0000}, // 4 R8 cancel
    {1'b0,8'h00,16'h8000, 1'b0,8'hEC,16'hFFFF, 1'b0,8'h00,16'h8000}, // 5 R5 shift 20
    {1'b0,8'hFE,16'h8000, 1'b1,8'h02,16'h8000, 1'b1,8'h01,16'hF000}, // 6 R4 B larger
    {1'b0,8'h00,16'h8000, 1'b0,8'hFF,16'h8001, 1'b0,8'h00,16'hC000}, // 7 R4 truncation
    {1'b0,8'h00,16'hFFFF, 1'b0,8'h00,16'h8000, 1'b0,8'h01,16'hBFFF}, // 8 R7 drop LSB
    {1'b0,8'h07,16'h8001, 1'b1,8'h07,16'h8000, 1'b0,8'hF8,16'h8000}, // 9 R9 lz 15
    {1'b0,8'h00,16'h8000, 1'b0,8'hF1,16'h8000, 1'b0,8'h00,16'h8001}, // 10 R5 shift 15
    {1'b0,8'h00,16'h8000, 1'b0,8'hF0,16'h8000, 1'b0,8'h00,16'h8000}, // 11 R5 shift 16
    {1'b1,8'h01,16'hC000, 1'b1,8'h01,16'hC000, 1'b1,8'h02,16'hC000}, // 12 R6 R7 negatives
    {1'b0,8'h7F,16'h8000, 1'b0,8'h80,16'h8000, 1'b0,8'h7F,16'h8000}, // 13 R4 R1 signed span
    {1'b0,8'h03,16'h0000, 1'b1,8'h01,16'h0000, 1'b0,8'h00,16'h0000}  // 14 R8 zero operands
  };

  function automatic string vtag(int i);
    case (i)
      0, 8:          return "R7";
      1, 6, 7:       return "R4";
      2, 9:          return "R9";
      3, 12:         return "R6";
      4, 14:         return "R8";
      5, 10, 11:     return "R5";
      default:       return "R1";
    endcase
  endfunction

  task automatic check_bit(string tag, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, expv);
    end
  endtask

  task automatic put(logic [74:0] v);
    in_valid = 1'b1;
    a_sign = v[74]; a_exp = v[73:66]; a_frac = v[65:50];
    b_sign = v[49]; b_exp = v[48:41]; b_frac = v[40:25];
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R2 watchdog: actual run still busy, expected completion");
    summary();
    $finish;
  end

  initial begin
    int rcv;
    // Reset state: R3, with a pair offered during reset.
    put(VEC[0]);
    repeat (3) @(negedge clk);
    check_bit("R3", out_valid, 1'b0, "out_valid during reset");
    rst_n = 1'b1;
    in_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check_bit("R3", out_valid, 1'b0, "out_valid after release");
    end

    // Table walk, streamed back to back: R2 order and latency, values per tag.
    rcv = 0;
    for (int it = 0; it < NV + 8; it++) begin
      @(negedge clk);
      if (out_valid) begin
        logic [74:0] v;
        checks++;
        if (rcv >= NV) begin
          fails++;
          $display("FAIL R2 extra result: actual %0d results expected %0d", rcv + 1, NV);
        end else begin
          v = VEC[rcv];
          if (out_sign !== v[24] || out_exp !== v[23:16] || out_frac !== v[15:0]) begin
            fails++;
            $display("FAIL %s vector %0d: actual %0b/%h/%h expected %0b/%h/%h",
                     vtag(rcv), rcv, out_sign, out_exp, out_frac, v[24], v[23:16], v[15:0]);
          end
          checks++;
          if (it != rcv + 4) begin
            fails++;
            $display("FAIL R2 latency vector %0d: actual %0d expected %0d", rcv, it - rcv, 4);
          end
        end
        rcv++;
      end
      if (it < NV) put(VEC[it]);
      else in_valid = 1'b0;
    end
    checks++;
    if (rcv != NV) begin
      fails++;
      $display("FAIL R2 result count: actual %0d expected %0d", rcv, NV);
    end

    // Burst of six pairs: R2, six results within 4+(6-1)=9 cycles.
    for (int k = 0; k <= 10; k++) begin
      @(negedge clk);
      if (k > 0) check_bit("R2", out_valid, (k >= 4 && k <= 9), $sformatf("burst cycle %0d", k));
      if (k < 6) put(VEC[1]);
      else in_valid = 1'b0;
    end

    // Reset in mid-stream discards work in flight: R3.
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      put(VEC[2]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check_bit("R3", out_valid, 1'b0, "out_valid in mid-stream reset");
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check_bit("R3", out_valid, 1'b0, "flushed work after reset");
    end

    summary();
    $finish;
  end
endmodule